// File: doc/BRIEF.md
# Paired-Word Instruction Fetch Sequencer

This block sits between a byte-addressed program memory and the execute stage of a small processor core. It holds the fetch and sequential program counters and reads one 16-bit word at a time. Each word lives at an even byte address. Four opcode families need a second word: an absolute jump, a call, a file-to-file move and a pointer-register load. When the first word of one of these arrives, the block fetches the following word and hands both to execute as a single operation. A word whose top nibble is 1111 and that arrives on its own is handed over marked as a no-operation. This lets a conditional skip land safely in the middle of a two-word operation.

Execute steers the sequencer with a single-cycle redirect. The redirect can carry an absolute word-address target, a signed branch offset counted in words, or a skip of one word. A redirect discards the operation currently offered and any memory read still outstanding. Fetching then restarts at the new byte address.

Both data paths use valid/ready. A memory request stays valid, with its address unchanged, until `mem_req_ready` is high at a clock edge. At most one read is outstanding. Read responses come back in order, one per accepted request, with any latency of one cycle or more, and they cannot be stalled. An offered operation holds all of its fields until `op_ready` is high at a clock edge. A redirect takes priority over both handshakes: in the cycle `redir_valid` is high, `op_ready` is ignored and the offered operation is dropped.

Top module: `ifs_fetch_seq`

## Requirements
- R1: While reset is asserted, `op_valid` is 0 and the block requests byte address 0. After reset, fetching starts at address 0.
- R2: Byte addresses are 21 bits wide and wrap modulo 2^21. A single-word operation is offered with `op_pc` equal to its byte address, `op_word1` = 0, and `op_pair` = `op_nop` = 0. The next operation's address is 2 higher.
- R3: A first word matching one of these patterns starts a pair: 1110_1111_xxxx_xxxx, 1110_110x_xxxx_xxxx, 1100_xxxx_xxxx_xxxx, or 1110_1110_00xx_xxxx. The word at the next address is then fetched and both are offered as one operation, with `op_pair` = 1, `op_word0` = first and `op_word1` = second. The next operation's address is 4 higher. Any other word, for example 1110_1110_01xx_xxxx, is a single-word operation.
- R4: A word with 1111 in bits 15:12 that is not the second word of a pair is offered with `op_nop` = 1 and `op_pair` = 0. `op_pair` and `op_nop` are never both 1.
- R5: A redirect of kind 0 (absolute) makes the next fetch address {`redir_word_addr`, 0}.
- R6: A redirect of kind 1 (relative) makes the next fetch address S + 2 × sign-extended `redir_offset`. S is the address following the last accepted operation.
- R7: A redirect of kind 2 (skip) makes the next fetch address S + 2. Skipping the first word of a pair therefore yields its second word as a lone no-operation.
- R8: In the cycle after `redir_valid` is high, `op_valid` is 0. Neither the operation offered during the redirect nor a read response still in flight is ever offered.
- R9: While `op_valid` is high and `op_ready` is low, all operation outputs hold. While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address hold (absent a redirect).
- R10: Every requested byte address is even. A new request is issued only when no read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 21 | Byte address of the requested word (even) |
| mem_rsp_valid | input | 1 | Read data valid, in request order |
| mem_rsp_data | input | 16 | Instruction word read |
| redir_valid | input | 1 | Single-cycle redirect from execute |
| redir_kind | input | 2 | 0 absolute, 1 relative, 2 skip |
| redir_word_addr | input | 20 | Absolute target as a word address |
| redir_offset | input | 11 | Signed relative offset in words |
| op_valid | output | 1 | Operation offered to execute |
| op_ready | input | 1 | Execute accepts the operation |
| op_pc | output | 21 | Byte address of the operation's first word |
| op_word0 | output | 16 | First (or only) word |
| op_word1 | output | 16 | Second word of a pair, else 0 |
| op_pair | output | 1 | Operation is a combined two-word instruction |
| op_nop | output | 1 | Lone 1111-prefix word, to retire as no-operation |

## Verification
The assertions check the cycle-level rules on every cycle: even request addresses, a single read outstanding, both handshakes holding under back-pressure, no operation in the cycle after a redirect, the absolute target landing in the fetch address, and the exclusive, prefix-consistent marking of no-operations. Only the bench's scenarios can show the rest. Those are the pairing decisions for each opcode family, including a near-miss pattern; the arithmetic of relative and skip targets against the sequential address; the dropping of a response already in flight; the skip that exposes a second word as a no-operation; and address wrap-around at the top of the 21-bit space.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    REDIR_ABS  = 2'd0,
    REDIR_REL  = 2'd1,
    REDIR_SKIP = 2'd2
  } redir_kind_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_WAIT  = 2'd1,
    ST_OUT   = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/ifs_pair_decode.sv
module ifs_pair_decode
  import ifs_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              starts_pair,
  output logic              tail_prefix
);
  localparam int NPAT = 4;
  // jump, call, file move, pointer load
  localparam logic [WORD_W-1:0] PAT [NPAT] = '{16'hEF00, 16'hEC00, 16'hC000, 16'hEE00};
  localparam logic [WORD_W-1:0] MSK [NPAT] = '{16'hFF00, 16'hFE00, 16'hF000, 16'hFFC0};

  logic [NPAT-1:0] hit;

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    assign hit[g] = ((word & MSK[g]) == PAT[g]);
  end

  assign starts_pair = |hit;
  assign tail_prefix = (word[WORD_W-1 -: 4] == 4'hF);
endmodule

// File: rtl/ifs_target_calc.sv
module ifs_target_calc
  import ifs_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int OFF_W = 11
) (
  input  logic [1:0]      kind,
  input  logic [PC_W-1:0] base,
  input  logic [PC_W-2:0] word_addr,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0] target
);
  localparam int EXT_W = PC_W - OFF_W;

  redir_kind_e     k;
  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] disp;

  assign k       = redir_kind_e'(kind);
  assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign disp    = {off_ext[PC_W-2:0], 1'b0};

  always_comb begin
    case (k)
      REDIR_ABS:  target = {word_addr, 1'b0};
      REDIR_REL:  target = base + disp;
      REDIR_SKIP: target = base + PC_W'(2);
      default:    target = base;
    endcase
  end
endmodule

// File: rtl/ifs_read_tracker.sv
module ifs_read_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic rsp_valid,
  input  logic flush,
  output logic pending,
  output logic rsp_take
);
  logic drop_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      if (req_fire)       pend_q <= 1'b1;
      else if (rsp_valid) pend_q <= 1'b0;

      if (flush && (req_fire || (pend_q && !rsp_valid))) drop_q <= 1'b1;
      else if (rsp_valid)                                  drop_q <= 1'b0;
    end
  end

  assign pending  = pend_q;
  assign rsp_take = rsp_valid && !drop_q && !flush;
endmodule

// File: rtl/ifs_fetch_seq.sv
module ifs_fetch_seq
  import ifs_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int OFF_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PC_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  input  logic              redir_valid,
  input  logic [1:0]        redir_kind,
  input  logic [PC_W-2:0]   redir_word_addr,
  input  logic [OFF_W-1:0]  redir_offset,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [PC_W-1:0]   op_pc,
  output logic [WORD_W-1:0] op_word0,
  output logic [WORD_W-1:0] op_word1,
  output logic              op_pair,
  output logic              op_nop
);
  localparam logic [PC_W-1:0] STEP1 = PC_W'(2);
  localparam logic [PC_W-1:0] STEP2 = PC_W'(4);

  fetch_state_e      state;
  logic [PC_W-1:0]   fetch_pc;
  logic [PC_W-1:0]   seq_pc;
  logic [PC_W-1:0]   cur_pc;
  logic [WORD_W-1:0] w0_q, w1_q;
  logic              pair_q, nop_q, want_tail;

  logic              pending, rsp_take, req_fire;
  logic              starts_pair, tail_prefix;
  logic [PC_W-1:0]   redir_tgt;

  ifs_pair_decode u_dec (
    .word        (mem_rsp_data),
    .starts_pair (starts_pair),
    .tail_prefix (tail_prefix)
  );

  ifs_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .kind      (redir_kind),
    .base      (seq_pc),
    .word_addr (redir_word_addr),
    .offset    (redir_offset),
    .target    (redir_tgt)
  );

  ifs_read_tracker u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .rsp_valid (mem_rsp_valid),
    .flush     (redir_valid),
    .pending   (pending),
    .rsp_take  (rsp_take)
  );

  assign mem_req_valid = (state == ST_FETCH) && !pending;
  assign mem_req_addr  = fetch_pc;
  assign req_fire      = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_FETCH;
      fetch_pc  <= '0;
      seq_pc    <= '0;
      cur_pc    <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      pair_q    <= 1'b0;
      nop_q     <= 1'b0;
      want_tail <= 1'b0;
    end else if (redir_valid) begin
      state     <= ST_FETCH;
      fetch_pc  <= redir_tgt;
      seq_pc    <= redir_tgt;
      want_tail <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: begin
          if (req_fire) begin
            fetch_pc <= fetch_pc + STEP1;
            state    <= ST_WAIT;
            if (!want_tail) cur_pc <= fetch_pc;
          end
        end
        ST_WAIT: begin
          if (rsp_take) begin
            if (!want_tail) begin
              w0_q <= mem_rsp_data;
              w1_q <= '0;
              if (starts_pair) begin
                want_tail <= 1'b1;
                pair_q    <= 1'b1;
                nop_q     <= 1'b0;
                state     <= ST_FETCH;
              end else begin
                pair_q <= 1'b0;
                nop_q  <= tail_prefix;
                state  <= ST_OUT;
              end
            end else begin
              w1_q      <= mem_rsp_data;
              want_tail <= 1'b0;
              state     <= ST_OUT;
            end
          end
        end
        ST_OUT: begin
          if (op_ready) begin
            seq_pc <= seq_pc + (pair_q ? STEP2 : STEP1);
            state  <= ST_FETCH;
          end
        end
        default: state <= ST_FETCH;
      endcase
    end
  end

  assign op_valid = (state == ST_OUT);
  assign op_pc    = cur_pc;
  assign op_word0 = w0_q;
  assign op_word1 = w1_q;
  assign op_pair  = pair_q;
  assign op_nop   = nop_q;
endmodule

// File: rtl/ifs_fetch_seq_chk.sv
module ifs_fetch_seq_chk
  import ifs_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int OFF_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [PC_W-1:0]   mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              redir_valid,
  input logic [1:0]        redir_kind,
  input logic [PC_W-2:0]   redir_word_addr,
  input logic              op_valid,
  input logic              op_ready,
  input logic [PC_W-1:0]   op_pc,
  input logic [WORD_W-1:0] op_word0,
  input logic [WORD_W-1:0] op_word1,
  input logic              op_pair,
  input logic              op_nop
);
  logic [1:0] outst;

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= '0;
    else outst <= outst + {1'b0, mem_req_valid && mem_req_ready} - {1'b0, mem_rsp_valid};
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !op_valid);

  p_pc_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !op_pc[0]);

  p_nop_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_nop) |-> (op_word0[WORD_W-1 -: 4] == 4'hF));

  p_kind_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !(op_pair && op_nop));

  p_abs_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_kind == REDIR_ABS) |=> (mem_req_addr == {$past(redir_word_addr), 1'b0}));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !op_valid);

  p_op_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready && !redir_valid) |=>
      (op_valid && $stable(op_pc) && $stable(op_word0) && $stable(op_word1)
       && $stable(op_pair) && $stable(op_nop)));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !redir_valid) |=>
      (mem_req_valid && $stable(mem_req_addr)));

  p_addr_even_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !mem_req_addr[0]);

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (outst == 2'd0));
endmodule

bind ifs_fetch_seq ifs_fetch_seq_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .mem_rsp_valid   (mem_rsp_valid),
  .redir_valid     (redir_valid),
  .redir_kind      (redir_kind),
  .redir_word_addr (redir_word_addr),
  .op_valid        (op_valid),
  .op_ready        (op_ready),
  .op_pc           (op_pc),
  .op_word0        (op_word0),
  .op_word1        (op_word1),
  .op_pair         (op_pair),
  .op_nop          (op_nop)
);

// File: tb/ifs_fetch_seq_tb.sv
module ifs_fetch_seq_tb_top;
  localparam int PC_W  = 21;
  localparam int OFF_W = 11;

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic [15:0]     w0;
    logic [15:0]     w1;
    logic            pair;
    logic            nop;
  } exp_t;

  // walked in order; R2 single, R3 pairs (all four families), R4 lone tail, R3 near-miss EE45
  localparam int NVEC = 10;
  localparam exp_t VEC [NVEC] = '{
    '{21'd0,  16'h0E55, 16'h0000, 1'b0, 1'b0},
    '{21'd2,  16'hEF12, 16'hF034, 1'b1, 1'b0},
    '{21'd6,  16'hC123, 16'hF456, 1'b1, 1'b0},
    '{21'd10, 16'hED40, 16'hF001, 1'b1, 1'b0},
    '{21'd14, 16'hEE05, 16'hF0AB, 1'b1, 1'b0},
    '{21'd18, 16'hF777, 16'h0000, 1'b0, 1'b1},
    '{21'd20, 16'hEE45, 16'h0000, 1'b0, 1'b0},
    '{21'd22, 16'h2400, 16'h0000, 1'b0, 1'b0},
    '{21'd24, 16'hEC11, 16'hF222, 1'b1, 1'b0},
    '{21'd28, 16'h6A00, 16'h0000, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mem_req_valid, mem_req_ready;
  logic [PC_W-1:0]   mem_req_addr;
  logic              mem_rsp_valid;
  logic [15:0]       mem_rsp_data;
  logic              redir_valid = 1'b0;
  logic [1:0]        redir_kind = 2'd0;
  logic [PC_W-2:0]   redir_word_addr = '0;
  logic [OFF_W-1:0]  redir_offset = '0;
  logic              op_valid;
  logic              op_ready = 1'b0;
  logic [PC_W-1:0]   op_pc;
  logic [15:0]       op_word0, op_word1;
  logic              op_pair, op_nop;

  int   checks = 0;
  int   errors = 0;
  logic stall_en = 1'b0;
  logic odd_seen = 1'b0;
  logic done = 1'b0;
  logic [7:0] cyc = '0;

  always #2.5 clk = ~clk;

  ifs_fetch_seq #(.PC_W(PC_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .redir_valid(redir_valid), .redir_kind(redir_kind),
    .redir_word_addr(redir_word_addr), .redir_offset(redir_offset),
    .op_valid(op_valid), .op_ready(op_ready), .op_pc(op_pc),
    .op_word0(op_word0), .op_word1(op_word1), .op_pair(op_pair), .op_nop(op_nop)
  );

  function automatic logic [15:0] prog(input logic [PC_W-1:0] a);
    case (a[7:1])
      7'd0:  return 16'h0E55;
      7'd1:  return 16'hEF12;
      7'd2:  return 16'hF034;
      7'd3:  return 16'hC123;
      7'd4:  return 16'hF456;
      7'd5:  return 16'hED40;
      7'd6:  return 16'hF001;
      7'd7:  return 16'hEE05;
      7'd8:  return 16'hF0AB;
      7'd9:  return 16'hF777;
      7'd10: return 16'hEE45;
      7'd11: return 16'h2400;
      7'd12: return 16'hEC11;
      7'd13: return 16'hF222;
      7'd14: return 16'h6A00;
      default: return 16'h0000;
    endcase
  endfunction

  assign mem_req_ready = !(stall_en && cyc[1:0] == 2'd1);

  always_ff @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data  <= prog(mem_req_addr);
      if (mem_req_valid && mem_req_addr[0]) odd_seen <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic wait_op();
    while (!op_valid) @(negedge clk);
  endtask

  task automatic chk_op(input exp_t e, input string req);
    exp_t g;
    g = '{op_pc, op_word0, op_word1, op_pair, op_nop};
    chk(g == e, req, "operation", 64'(g), 64'(e));
  endtask

  // accept the offered op, then redirect one cycle later (hits in-flight read)
  task automatic accept_then_redir(input logic [1:0] k, input logic [PC_W-2:0] wa,
                                   input logic [OFF_W-1:0] off);
    op_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_ready = 1'b0;
    redir_valid = 1'b1; redir_kind = k; redir_word_addr = wa; redir_offset = off;
    @(posedge clk);
    @(negedge clk);
    redir_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!op_valid, "R1", "op_valid in reset", 64'(op_valid), 64'd0);
    chk(mem_req_valid && mem_req_addr == '0, "R1", "request addr in reset",
        64'(mem_req_addr), 64'd0);
    rst_n = 1'b1;
    stall_en = 1'b1;
    op_ready = 1'b1;

    // table walk: R2, R3, R4 with memory back-pressure (R9)
    for (int i = 0; i < NVEC; i++) begin
      wait_op();
      chk_op(VEC[i], "R2/R3/R4 walk");
      @(posedge clk);
      @(negedge clk);
    end
    op_ready = 1'b0;
    stall_en = 1'b0;

    // R9: operation holds under back-pressure
    wait_op();
    chk_op('{21'd30, 16'h0000, 16'h0000, 1'b0, 1'b0}, "R2");
    repeat (3) @(negedge clk);
    chk_op('{21'd30, 16'h0000, 16'h0000, 1'b0, 1'b0}, "R9 hold");

    // R5 + R8: absolute redirect while next read in flight
    accept_then_redir(2'd0, 20'd5, '0);
    wait_op();
    chk_op('{21'd10, 16'hED40, 16'hF001, 1'b1, 1'b0}, "R5 R8 abs");

    // R8 + R6: redirect while offered, op_ready ignored, base stays 10
    op_ready = 1'b1;
    redir_valid = 1'b1; redir_kind = 2'd1; redir_offset = 11'h7FD; // -3
    @(posedge clk);
    @(negedge clk);
    redir_valid = 1'b0;
    op_ready = 1'b0;
    chk(!op_valid, "R8", "op_valid after redirect", 64'(op_valid), 64'd0);
    wait_op();
    chk_op('{21'd4, 16'hF034, 16'h0000, 1'b0, 1'b1}, "R6 R4 rel neg");

    // R7: skip the first word of the move at 6 -> lone tail at 8
    accept_then_redir(2'd2, '0, '0);
    wait_op();
    chk_op('{21'd8, 16'hF456, 16'h0000, 1'b0, 1'b1}, "R7 skip");

    // R5: absolute to top of space, then R2 wrap to 0
    accept_then_redir(2'd0, 20'hFFFFF, '0);
    wait_op();
    chk_op('{21'h1FFFFE, 16'h0000, 16'h0000, 1'b0, 1'b0}, "R5 top");
    op_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_ready = 1'b0;
    wait_op();
    chk_op('{21'd0, 16'h0E55, 16'h0000, 1'b0, 1'b0}, "R2 wrap");

    // R6: positive relative from 2 by +9 words -> 20
    accept_then_redir(2'd1, '0, 11'd9);
    wait_op();
    chk_op('{21'd20, 16'hEE45, 16'h0000, 1'b0, 1'b0}, "R6 rel pos");

    // R10: no odd request address seen
    chk(!odd_seen, "R10", "odd address", 64'(odd_seen), 64'd0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule